// File: doc/BRIEF.md
# ROM Sweep Address Counter

This block walks a word-addressed ROM from address zero to its highest word exactly once after reset. It drives the ROM read port (address plus request strobe) and keeps a second pointer to the word currently offered to a downstream consumer. The consumer takes a word by raising a ready input while the word is valid. The ROM answers one cycle after a request, so the offered-word pointer trails the request pointer by one stage.

The ROM has two regions. The low region is streamed to a hash engine. The top `TOP_COUNT` words hold an expected digest. The block marks the final word of the low region so that the consumer can close its message. Once the word at the highest address has been accepted, it raises a completion flag that never falls again. A consumer may treat any later drop of that flag as tampering.

A new read is issued only when the data slot is empty or is being emptied in the same cycle. A stall therefore neither skips nor repeats a word, and the ROM output register only has to hold its value while the consumer is not ready.

Top module: `rom_sweep_counter`

## Requirements
- R1: After the synchronous active-high reset `rst` is released, `rd_addr_o` is 0, `data_vld_o`, `low_last_o` and `sweep_done_o` are 0, and `rd_req_o` is 1 (the first read starts at once).
- R2: `rd_req_o` is 1 only while no word is offered, or while the offered word is accepted in the same cycle (`data_vld_o` and `data_rdy_i` both 1).
- R3: A request for address A in one cycle makes `data_vld_o` 1 and `data_addr_o` equal to A in the next cycle.
- R4: Read requests cover the addresses 0 to ROM_DEPTH-1 in increasing order, each exactly once. The offered words are accepted in the same order, each exactly once.
- R5: While a word is offered and `data_rdy_i` is 0, `data_addr_o`, `data_vld_o` and `rd_addr_o` hold, and no request is issued.
- R6: `low_last_o` is 1 exactly while a valid word at address ROM_DEPTH-TOP_COUNT-1 is offered, so it marks exactly one accepted word per sweep.
- R7: `sweep_done_o` rises in the cycle after the word at ROM_DEPTH-1 is accepted, not before, and stays 1 until reset.
- R8: While `sweep_done_o` is 1, `rd_req_o` and `data_vld_o` are 0 and `rd_addr_o` holds ROM_DEPTH-1.
- R9: A reset asserted in the middle of a sweep abandons it, and the next sweep restarts from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| data_rdy_i | input | 1 | Consumer accepts the offered word |
| rd_req_o | output | 1 | ROM read strobe for `rd_addr_o` |
| rd_addr_o | output | AW | ROM read address |
| data_vld_o | output | 1 | A ROM word is on offer |
| data_addr_o | output | AW | Address of the word on offer |
| low_last_o | output | 1 | Word on offer is the last word of the low region |
| sweep_done_o | output | 1 | Whole ROM accepted (sticky) |

AW is max(1, ceil(log2(ROM_DEPTH))).

## Verification
A corrupted request pointer shows up at the ROM port in the same cycle, as an address out of sequence or as a strobe during a stall. The scoreboard of expected read addresses catches it on the first wrong request. A bad data pointer or slot flag shows one cycle later, as an offered address that differs from the one requested, or as a word lost or duplicated at acceptance. A done flag that is early, late or drops is caught within one cycle of the final acceptance, or in any later cycle. The bench runs sweeps with a consumer that is always ready, one that stalls at random, and one that stalls in long bursts, plus a reset in the middle of a sweep.

// File: rtl/rom_sweep_pkg.sv
package rom_sweep_pkg;

  // Address width for a ROM of the given depth, never below one bit.
  function automatic int addr_bits(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  // Address of the last word below the digest region.
  function automatic int low_last_index(input int depth, input int top);
    return depth - top - 1;
  endfunction

endpackage

// File: rtl/sweep_req_ptr.sv
module sweep_req_ptr #(
  parameter int ROM_DEPTH = 64,
  parameter int AW        = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slot_free_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(ROM_DEPTH - 1);

  logic [AW-1:0] addr_q;
  logic          issued_all_q;

  // A read goes out only when its data can land in a free slot.
  assign rd_req_o  = !issued_all_q && slot_free_i;
  assign rd_addr_o = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q       <= '0;
      issued_all_q <= 1'b0;
    end else if (rd_req_o) begin
      if (addr_q == LAST_ADDR) begin
        issued_all_q <= 1'b1;
      end else begin
        addr_q <= addr_q + 1'b1;
      end
    end
  end

  // R4: each request below the top moves the pointer to the next word
  p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && rd_addr_o != LAST_ADDR) |=> (rd_addr_o == $past(rd_addr_o) + 1'b1));

  // R8: once the last address has been requested, the pointer freezes and reads stop
  p_freeze_after_last_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && rd_addr_o == LAST_ADDR) |=> (!rd_req_o && rd_addr_o == LAST_ADDR));

endmodule

// File: rtl/sweep_data_slot.sv
module sweep_data_slot #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_req_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic          data_rdy_i,
  output logic          slot_free_o,
  output logic          accept_o,
  output logic          vld_o,
  output logic [AW-1:0] addr_o
);
  logic          vld_q;
  logic [AW-1:0] addr_q;

  assign accept_o    = vld_q && data_rdy_i;
  assign slot_free_o = !vld_q || data_rdy_i;
  assign vld_o       = vld_q;
  assign addr_o      = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
    end else if (rd_req_i) begin
      vld_q  <= 1'b1;
      addr_q <= rd_addr_i;
    end else if (accept_o) begin
      vld_q <= 1'b0;
    end
  end

  // R3: the word requested in one cycle is on offer in the next
  p_fill_r3: assert property (@(posedge clk) disable iff (rst)
    rd_req_i |=> (vld_o && addr_o == $past(rd_addr_i)));

  // R5: a stalled word stays put
  p_stall_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (vld_o && !data_rdy_i) |=> (vld_o && $stable(addr_o)));

endmodule

// File: rtl/sweep_status.sv
module sweep_status #(
  parameter int ROM_DEPTH = 64,
  parameter int TOP_COUNT = 8,
  parameter int AW        = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vld_i,
  input  logic [AW-1:0] addr_i,
  input  logic          accept_i,
  output logic          low_last_o,
  output logic          done_o
);
  import rom_sweep_pkg::*;

  localparam logic [AW-1:0] LAST_ADDR = AW'(ROM_DEPTH - 1);
  localparam logic [AW-1:0] LOW_LAST  = AW'(low_last_index(ROM_DEPTH, TOP_COUNT));

  logic done_q;

  assign low_last_o = vld_i && (addr_i == LOW_LAST);
  assign done_o     = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
    end else if (accept_i && addr_i == LAST_ADDR) begin
      done_q <= 1'b1;
    end
  end

  // R7: completion never drops before reset
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> done_o);

  // R7: completion only follows acceptance of the top word
  p_done_cause_r7: assert property (@(posedge clk) disable iff (rst)
    (!done_o && !(accept_i && addr_i == LAST_ADDR)) |=> !done_o);

endmodule

// File: rtl/rom_sweep_counter.sv
module rom_sweep_counter #(
  parameter int ROM_DEPTH = 64,
  parameter int TOP_COUNT = 8,
  localparam int AW = rom_sweep_pkg::addr_bits(ROM_DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          data_rdy_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          data_vld_o,
  output logic [AW-1:0] data_addr_o,
  output logic          low_last_o,
  output logic          sweep_done_o
);
  logic slot_free;
  logic accept;

  sweep_req_ptr #(
    .ROM_DEPTH (ROM_DEPTH),
    .AW        (AW)
  ) u_req (
    .clk         (clk),
    .rst         (rst),
    .slot_free_i (slot_free),
    .rd_req_o    (rd_req_o),
    .rd_addr_o   (rd_addr_o)
  );

  sweep_data_slot #(
    .AW (AW)
  ) u_slot (
    .clk         (clk),
    .rst         (rst),
    .rd_req_i    (rd_req_o),
    .rd_addr_i   (rd_addr_o),
    .data_rdy_i  (data_rdy_i),
    .slot_free_o (slot_free),
    .accept_o    (accept),
    .vld_o       (data_vld_o),
    .addr_o      (data_addr_o)
  );

  sweep_status #(
    .ROM_DEPTH (ROM_DEPTH),
    .TOP_COUNT (TOP_COUNT),
    .AW        (AW)
  ) u_status (
    .clk        (clk),
    .rst        (rst),
    .vld_i      (data_vld_o),
    .addr_i     (data_addr_o),
    .accept_i   (accept),
    .low_last_o (low_last_o),
    .done_o     (sweep_done_o)
  );

  // R8: after completion the ROM port and the data slot stay quiet
  p_quiet_after_done_r8: assert property (@(posedge clk) disable iff (rst)
    sweep_done_o |-> (!rd_req_o && !data_vld_o));

  // R2: no read is issued over a stalled word
  p_no_req_on_stall_r2: assert property (@(posedge clk) disable iff (rst)
    (data_vld_o && !data_rdy_i) |-> !rd_req_o);

endmodule

// File: tb/rom_sweep_counter_test.sv
module rom_sweep_counter_test;
  localparam int D  = 64;
  localparam int T  = 8;
  localparam int AW = rom_sweep_pkg::addr_bits(D);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          data_rdy_i = 1'b0;
  logic          rd_req_o;
  logic [AW-1:0] rd_addr_o;
  logic          data_vld_o;
  logic [AW-1:0] data_addr_o;
  logic          low_last_o;
  logic          sweep_done_o;

  int tests = 0;
  int fails = 0;
  int acc_cnt = 0;
  int last_cnt = 0;
  bit finished = 1'b0;

  int exp_req[$];
  int exp_data[$];

  always #4 clk = ~clk;

  rom_sweep_counter #(.ROM_DEPTH(D), .TOP_COUNT(T)) uut (
    .clk(clk), .rst(rst), .data_rdy_i(data_rdy_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .data_vld_o(data_vld_o), .data_addr_o(data_addr_o),
    .low_last_o(low_last_o), .sweep_done_o(sweep_done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor / scoreboard, sampling at the falling edge
  bit prev_req, prev_stall, prev_final, done_seen;
  int prev_req_addr, prev_data_addr, prev_rd_addr;

  always @(negedge clk) begin
    if (rst) begin
      prev_req = 0; prev_stall = 0; prev_final = 0; done_seen = 0;
    end else begin
      if (prev_req)
        chk(data_vld_o && int'(data_addr_o) == prev_req_addr, "R3", int'(data_addr_o), prev_req_addr);
      if (prev_stall) begin
        chk(data_vld_o && int'(data_addr_o) == prev_data_addr, "R5 data hold", int'(data_addr_o), prev_data_addr);
        chk(int'(rd_addr_o) == prev_rd_addr, "R5 read hold", int'(rd_addr_o), prev_rd_addr);
      end
      if (data_vld_o && !data_rdy_i)
        chk(!rd_req_o, "R2", int'(rd_req_o), 0);
      if (rd_req_o) begin
        if (exp_req.size() == 0) chk(1'b0, "R4 extra request", int'(rd_addr_o), -1);
        else begin
          int e;
          e = exp_req.pop_front();
          chk(int'(rd_addr_o) == e, "R4 request order", int'(rd_addr_o), e);
        end
      end
      chk(low_last_o == (data_vld_o && int'(data_addr_o) == D - T - 1), "R6",
          int'(low_last_o), int'(data_vld_o && int'(data_addr_o) == D - T - 1));
      if (data_vld_o && data_rdy_i) begin
        acc_cnt++;
        if (low_last_o) last_cnt++;
        if (exp_data.size() == 0) chk(1'b0, "R4 extra word", int'(data_addr_o), -1);
        else begin
          int e;
          e = exp_data.pop_front();
          chk(int'(data_addr_o) == e, "R4 accept order", int'(data_addr_o), e);
        end
      end
      if (prev_final) chk(sweep_done_o, "R7 done rise", int'(sweep_done_o), 1);
      else if (!done_seen) chk(!sweep_done_o, "R7 early done", int'(sweep_done_o), 0);
      if (done_seen) chk(sweep_done_o, "R7 sticky", int'(sweep_done_o), 1);
      if (sweep_done_o) begin
        chk(!rd_req_o && !data_vld_o, "R8 quiet", int'({rd_req_o, data_vld_o}), 0);
        chk(int'(rd_addr_o) == D - 1, "R8 addr hold", int'(rd_addr_o), D - 1);
      end
      done_seen      = done_seen | sweep_done_o;
      prev_req       = rd_req_o;
      prev_req_addr  = int'(rd_addr_o);
      prev_stall     = data_vld_o && !data_rdy_i;
      prev_data_addr = int'(data_addr_o);
      prev_rd_addr   = int'(rd_addr_o);
      prev_final     = data_vld_o && data_rdy_i && int'(data_addr_o) == D - 1;
    end
  end

  // Driver: reset, refill the expected queues, release
  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1;
    data_rdy_i = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    exp_req.delete();
    exp_data.delete();
    for (int a = 0; a < D; a++) begin
      exp_req.push_back(a);
      exp_data.push_back(a);
    end
    acc_cnt = 0;
    last_cnt = 0;
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk(int'(rd_addr_o) == 0, "R1 addr", int'(rd_addr_o), 0);
    chk(rd_req_o, "R1 req", int'(rd_req_o), 1);
    chk(!data_vld_o && !low_last_o && !sweep_done_o, "R1 flags",
        int'({data_vld_o, low_last_o, sweep_done_o}), 0);
  endtask

  // mode 0: always ready, 1: random, 2: long stall bursts
  task automatic drive(input int mode, input int stop_at);
    int burst = 0;
    int guard = 0;
    while (!sweep_done_o && acc_cnt < stop_at && guard < 20000) begin
      @(posedge clk); #1;
      guard++;
      case (mode)
        0: data_rdy_i = 1'b1;
        1: data_rdy_i = ($urandom_range(0, 1) == 1);
        default: begin
          if (burst > 0) begin
            burst--;
            data_rdy_i = 1'b0;
          end else if ($urandom_range(0, 3) == 0) begin
            burst = $urandom_range(3, 9);
            data_rdy_i = 1'b0;
          end else data_rdy_i = 1'b1;
        end
      endcase
    end
  endtask

  task automatic finish_sweep(input string tag);
    repeat (12) begin
      @(posedge clk); #1;
      data_rdy_i = ($urandom_range(0, 1) == 1);
    end
    @(negedge clk);
    chk(sweep_done_o, {"R7 ", tag}, int'(sweep_done_o), 1);
    chk(exp_req.size() == 0 && exp_data.size() == 0, {"R4 all seen ", tag},
        exp_req.size() + exp_data.size(), 0);
    chk(acc_cnt == D, {"R4 count ", tag}, acc_cnt, D);
    chk(last_cnt == 1, {"R6 one mark ", tag}, last_cnt, 1);
  endtask

  initial begin
    do_reset();
    drive(0, D + 1);
    finish_sweep("ready");

    // R9: reset part way through a stalled sweep
    do_reset();
    drive(1, 20);
    chk(!sweep_done_o && acc_cnt >= 20, "R9 partial", acc_cnt, 20);
    do_reset();
    drive(1, D + 1);
    finish_sweep("random");

    do_reset();
    drive(2, D + 1);
    finish_sweep("burst");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule